// File: doc/BRIEF.md
# Panel-Mode / MPPT Supervisory Sequencer

This block decides which operating regime a four-switch buck-boost photovoltaic optimizer is in. After reset it ramps the output through a fixed soft-start. It then either hands control to the maximum-power-point tracker or parks the converter in a startup panel hold. From tracking it drops into panel (pass-through) mode once the converter has sat at a 1:1 voltage ratio long enough. It leaves panel mode again when output power drifts by a set fraction from its value at entry. While in panel mode it periodically lets the tracker run for a bounded recheck window.

Inputs are the sampled output current and output power, a flag from the converter saying it is at 1:1 ratio, two 3-bit configuration codes decoded from the board's configuration levels, an active-low force pin with a register override, and a synchronous reset. Outputs are the current mode, a soft-start enable for the ramp generator, and a square wave (nominally 400 kHz) that drives the bypass FET driver and runs only while a panel regime is active. All durations count in ticks of a prescaled time base. One tick is nominally 10 ms, so the duration parameters are written in 10 ms units. Every timer restarts whenever the state changes.

Top module: `pmode_supervisor`

## Requirements
- R1: `mode` encodes OFF=0, SOFT=1, HOLD=2, MPPT=3, RECHECK=4, PANEL=5. After reset is released the block spends one cycle in OFF, then exactly T_SOFT ticks in SOFT. `ss_en` is 1 only in SOFT.
- R2: When SOFT ends, the next state is MPPT if `iout` reached the start threshold at any point during SOFT. Otherwise the next state is HOLD.
- R3: HOLD moves to MPPT when `iout` is at or above the start threshold and at least the hold time has elapsed. The hold time counts only from the first cycle in HOLD at or above the start threshold. The hold time is set by `start_cfg`: codes 7, 5 and 3 give none, code 4 gives T_HOLD_LONG, and codes 6, 2, 1 and 0 give T_HOLD_SHORT.
- R4: Current thresholds form an exit/start pair set by `start_cfg`. Code 7 gives 0/0, code 6 gives TH_LIGHT_LO/TH_LIGHT_HI, and all other codes give TH_HEAVY_LO/TH_HEAVY_HI. MPPT or RECHECK moves to HOLD when `iout` is strictly below the exit threshold. A current between the two thresholds changes nothing.
- R5: MPPT moves to PANEL after `unity_ratio` has been 1 for an unbroken run of T_DWELL_BASE·m ticks, where m is 1, 2, 5 or 10 for `entry_cfg[1:0]` = 0, 1, 2 or 3. A 0 on `unity_ratio` restarts the run.
- R6: On entry to PANEL, `pout` is captured as a reference. PANEL moves to MPPT when |pout − ref| exceeds ref>>5 (when `entry_cfg[2]`=1) or ref>>6 (when `entry_cfg[2]`=0). A deviation exactly equal to the limit stays in PANEL.
- R7: After T_RECHECK ticks in PANEL, the block enters RECHECK. RECHECK returns to PANEL after T_WINDOW ticks, or earlier through the R5 dwell rule.
- R8: The force request is `ovr_panel` when `ovr_sel`=1, and `!pm_force_n` otherwise. A force request moves MPPT or RECHECK to PANEL on the next cycle, sends a completed HOLD to PANEL instead of MPPT, and blocks the power and recheck exits from PANEL.
- R9: `sq_out` toggles every SQ_HALF cycles while the state is HOLD or PANEL. It is 0 from the cycle after any other state is entered.
- R10: While `rst` is 1, the state is OFF and `ss_en` and `sq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iout | input | IW | Sampled output current code |
| pout | input | PW | Sampled output power code |
| unity_ratio | input | 1 | Converter is at 1:1 ratio |
| pm_force_n | input | 1 | Panel force pin, active low |
| ovr_sel | input | 1 | Use ovr_panel instead of the pin |
| ovr_panel | input | 1 | Register force value |
| entry_cfg | input | 3 | Dwell time and power-exit fraction code |
| start_cfg | input | 3 | Startup hold and current threshold code |
| mode | output | 3 | Current state code |
| ss_en | output | 1 | Soft-start ramp enable |
| sq_out | output | 1 | Panel-mode square wave |

## Verification
The bench builds the block with TICK_DIV=1, which makes every 10 ms unit a single clock cycle, and with SQ_HALF=4, which gives an 8-cycle square-wave period. The one-minute recheck and two-minute startup hold then last a few thousand cycles. At that length every timer boundary can be checked on its exact cycle instead of within a tolerance. The default-length thresholds and dwell multipliers are kept, so every `start_cfg` and `entry_cfg` code is reached with its real ratios.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef enum logic [2:0] {
        MD_OFF     = 3'd0,
        MD_SOFT    = 3'd1,
        MD_HOLD    = 3'd2,
        MD_MPPT    = 3'd3,
        MD_RECHECK = 3'd4,
        MD_PANEL   = 3'd5
    } pm_state_e;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_SHORT = 2'd1,
        HOLD_LONG  = 2'd2
    } hold_kind_e;

    typedef enum logic [1:0] {
        TH_NONE  = 2'd0,
        TH_LIGHT = 2'd1,
        TH_HEAVY = 2'd2
    } th_kind_e;

    typedef struct packed {
        logic [3:0] dwell_mult;
        logic       fine_pct;
        hold_kind_e hold;
        th_kind_e   th;
    } cfg_sel_t;

    function automatic cfg_sel_t decode_cfg(input logic [2:0] entry, input logic [2:0] start);
        cfg_sel_t c;
        case (entry[1:0])
            2'd0:    c.dwell_mult = 4'd1;
            2'd1:    c.dwell_mult = 4'd2;
            2'd2:    c.dwell_mult = 4'd5;
            default: c.dwell_mult = 4'd10;
        endcase
        c.fine_pct = ~entry[2];
        case (start)
            3'd7:    begin c.hold = HOLD_NONE;  c.th = TH_NONE;  end
            3'd6:    begin c.hold = HOLD_SHORT; c.th = TH_LIGHT; end
            3'd5:    begin c.hold = HOLD_NONE;  c.th = TH_HEAVY; end
            3'd4:    begin c.hold = HOLD_LONG;  c.th = TH_HEAVY; end
            3'd3:    begin c.hold = HOLD_NONE;  c.th = TH_HEAVY; end
            default: begin c.hold = HOLD_SHORT; c.th = TH_HEAVY; end
        endcase
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pmode_tick.sv
module pmode_tick #(
    parameter int TICK_DIV = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/pmode_cfg.sv
module pmode_cfg
    import pmode_pkg::*;
#(
    parameter int IW           = 10,
    parameter int TW           = 16,
    parameter int DW           = 8,
    parameter int T_DWELL_BASE = 20,
    parameter int T_HOLD_SHORT = 6000,
    parameter int T_HOLD_LONG  = 12000,
    parameter int TH_LIGHT_LO  = 15,
    parameter int TH_LIGHT_HI  = 25,
    parameter int TH_HEAVY_LO  = 60,
    parameter int TH_HEAVY_HI  = 100
) (
    input  logic [2:0]    entry_cfg,
    input  logic [2:0]    start_cfg,
    output logic [DW-1:0] dwell_ticks,
    output logic [TW-1:0] hold_ticks,
    output logic [IW-1:0] th_lo,
    output logic [IW-1:0] th_hi,
    output logic          fine_pct
);
    cfg_sel_t sel;

    always_comb begin
        sel         = decode_cfg(entry_cfg, start_cfg);
        dwell_ticks = DW'(T_DWELL_BASE * int'(sel.dwell_mult));
        fine_pct    = sel.fine_pct;
        case (sel.hold)
            HOLD_SHORT: hold_ticks = TW'(T_HOLD_SHORT);
            HOLD_LONG:  hold_ticks = TW'(T_HOLD_LONG);
            default:    hold_ticks = '0;
        endcase
        case (sel.th)
            TH_LIGHT: begin th_lo = IW'(TH_LIGHT_LO); th_hi = IW'(TH_LIGHT_HI); end
            TH_HEAVY: begin th_lo = IW'(TH_HEAVY_LO); th_hi = IW'(TH_HEAVY_HI); end
            default:  begin th_lo = '0;               th_hi = '0;               end
        endcase
    end
endmodule

// File: rtl/pmode_pwr.sv
module pmode_pwr #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [PW-1:0] pout,
    input  logic          fine_pct,
    output logic          deviate
);
    logic [PW-1:0] ref_q;
    logic [PW-1:0] delta;
    logic [PW-1:0] limit;

    always_ff @(posedge clk) begin
        if (rst)          ref_q <= '0;
        else if (capture) ref_q <= pout;
    end

    always_comb begin
        delta   = (pout > ref_q) ? (pout - ref_q) : (ref_q - pout);
        limit   = fine_pct ? (ref_q >> 6) : (ref_q >> 5);
        deviate = (delta > limit);
    end

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(ref_q)) else $error("reference moved without capture"); // R6
endmodule

// File: rtl/pmode_sqwave.sv
module pmode_sqwave #(
    parameter int SQ_HALF = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic sq
);
    localparam int HW = (SQ_HALF > 1) ? $clog2(SQ_HALF) : 1;
    localparam logic [HW-1:0] LAST = HW'(SQ_HALF - 1);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            sq  <= ~sq;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SQ_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !active |=> !sq) else $error("square wave outside panel regime"); // R9
endmodule

// File: rtl/pmode_supervisor.sv
module pmode_supervisor
    import pmode_pkg::*;
#(
    parameter int TICK_DIV     = 1_000_000,
    parameter int SQ_HALF      = 125,
    parameter int IW           = 10,
    parameter int PW           = 16,
    parameter int T_SOFT       = 25,
    parameter int T_HOLD_SHORT = 6000,
    parameter int T_HOLD_LONG  = 12000,
    parameter int T_RECHECK    = 6000,
    parameter int T_WINDOW     = 400,
    parameter int T_DWELL_BASE = 20,
    parameter int TH_LIGHT_LO  = 15,
    parameter int TH_LIGHT_HI  = 25,
    parameter int TH_HEAVY_LO  = 60,
    parameter int TH_HEAVY_HI  = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] iout,
    input  logic [PW-1:0] pout,
    input  logic          unity_ratio,
    input  logic          pm_force_n,
    input  logic          ovr_sel,
    input  logic          ovr_panel,
    input  logic [2:0]    entry_cfg,
    input  logic [2:0]    start_cfg,
    output logic [2:0]    mode,
    output logic          ss_en,
    output logic          sq_out
);
    localparam int T_MAX = max3(max3(T_SOFT, T_HOLD_SHORT, T_HOLD_LONG), T_RECHECK, T_WINDOW);
    localparam int TW    = $clog2(T_MAX + 2);
    localparam int DW    = $clog2(T_DWELL_BASE * 10 + 2);

    pm_state_e     st, nxt;
    logic          tick;
    logic [TW-1:0] st_cnt;
    logic [DW-1:0] dw_cnt;
    logic          armed, hi_seen;
    logic [DW-1:0] dwell_ticks;
    logic [TW-1:0] hold_ticks;
    logic [IW-1:0] th_lo, th_hi;
    logic          fine_pct, deviate;
    logic          force_req, iout_hi, iout_low;
    logic          soft_done, hold_met, dwell_done, rc_done, win_done;
    logic          cnt_en, capture, panel_on;

    pmode_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

    pmode_cfg #(
        .IW(IW), .TW(TW), .DW(DW), .T_DWELL_BASE(T_DWELL_BASE),
        .T_HOLD_SHORT(T_HOLD_SHORT), .T_HOLD_LONG(T_HOLD_LONG),
        .TH_LIGHT_LO(TH_LIGHT_LO), .TH_LIGHT_HI(TH_LIGHT_HI),
        .TH_HEAVY_LO(TH_HEAVY_LO), .TH_HEAVY_HI(TH_HEAVY_HI)
    ) u_cfg (
        .entry_cfg(entry_cfg), .start_cfg(start_cfg), .dwell_ticks(dwell_ticks),
        .hold_ticks(hold_ticks), .th_lo(th_lo), .th_hi(th_hi), .fine_pct(fine_pct)
    );

    pmode_pwr #(.PW(PW)) u_pwr (
        .clk(clk), .rst(rst), .capture(capture), .pout(pout),
        .fine_pct(fine_pct), .deviate(deviate)
    );

    pmode_sqwave #(.SQ_HALF(SQ_HALF)) u_sq (
        .clk(clk), .rst(rst), .active(panel_on), .sq(sq_out)
    );

    // condition decode
    always_comb begin
        force_req  = ovr_sel ? ovr_panel : ~pm_force_n;
        iout_hi    = (iout >= th_hi);
        iout_low   = (iout < th_lo);
        soft_done  = tick && (st_cnt >= TW'(T_SOFT - 1));
        hold_met   = (st_cnt >= hold_ticks);
        dwell_done = unity_ratio && tick && (dw_cnt >= dwell_ticks - 1'b1);
        rc_done    = tick && (st_cnt >= TW'(T_RECHECK - 1));
        win_done   = tick && (st_cnt >= TW'(T_WINDOW - 1));
        cnt_en     = (st != MD_HOLD) || armed || iout_hi;
        panel_on   = (st == MD_HOLD) || (st == MD_PANEL);
    end

    // next-state logic
    always_comb begin
        nxt = st;
        case (st)
            MD_OFF:  nxt = MD_SOFT;
            MD_SOFT: if (soft_done) nxt = (hi_seen || iout_hi) ? MD_MPPT : MD_HOLD;
            MD_HOLD: if (iout_hi && hold_met) nxt = force_req ? MD_PANEL : MD_MPPT;
            MD_MPPT: begin
                if (force_req)       nxt = MD_PANEL;
                else if (iout_low)   nxt = MD_HOLD;
                else if (dwell_done) nxt = MD_PANEL;
            end
            MD_RECHECK: begin
                if (force_req)       nxt = MD_PANEL;
                else if (iout_low)   nxt = MD_HOLD;
                else if (dwell_done) nxt = MD_PANEL;
                else if (win_done)   nxt = MD_PANEL;
            end
            MD_PANEL: begin
                if (!force_req) begin
                    if (deviate)      nxt = MD_MPPT;
                    else if (rc_done) nxt = MD_RECHECK;
                end
            end
            default: nxt = MD_OFF;
        endcase
        capture = (nxt == MD_PANEL) && (st != MD_PANEL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= MD_OFF;
            st_cnt  <= '0;
            dw_cnt  <= '0;
            armed   <= 1'b0;
            hi_seen <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt != st) begin
                st_cnt  <= '0;
                armed   <= 1'b0;
                hi_seen <= 1'b0;
            end else begin
                if (tick && cnt_en && st_cnt != '1) st_cnt <= st_cnt + 1'b1;
                if (st == MD_HOLD && iout_hi) armed   <= 1'b1;
                if (st == MD_SOFT && iout_hi) hi_seen <= 1'b1;
            end
            if (nxt != st || !unity_ratio) dw_cnt <= '0;
            else if (tick && dw_cnt != '1) dw_cnt <= dw_cnt + 1'b1;
        end
    end

    assign mode  = st;
    assign ss_en = (st == MD_SOFT);

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (st == MD_OFF && !sq_out)) else $error("reset not quiet"); // R10
    AST_OFF_TO_SOFT: assert property (@(posedge clk) disable iff (rst)
        (st == MD_OFF) |=> (st == MD_SOFT)) else $error("OFF did not start ramp"); // R1
    AST_SOFT_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(ss_en) |-> (st == MD_MPPT || st == MD_HOLD)) else $error("bad soft exit"); // R2
    AST_FORCE_PANEL: assert property (@(posedge clk) disable iff (rst)
        (force_req && (st == MD_MPPT || st == MD_RECHECK)) |=> (st == MD_PANEL)) else $error("force ignored"); // R8
    AST_NO_DWELL_PANEL: assert property (@(posedge clk) disable iff (rst)
        (st == MD_MPPT && !unity_ratio && !force_req) |=> (st != MD_PANEL)) else $error("panel without dwell"); // R5
endmodule

// File: tb/pmode_supervisor_tb.sv
module pmode_supervisor_tb;
    localparam int MD_OFF = 0, MD_SOFT = 1, MD_HOLD = 2, MD_MPPT = 3, MD_RECHECK = 4, MD_PANEL = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  iout = '0;
    logic [15:0] pout = 16'd1000;
    logic        unity_ratio = 1'b0;
    logic        pm_force_n = 1'b1;
    logic        ovr_sel = 1'b0;
    logic        ovr_panel = 1'b0;
    logic [2:0]  entry_cfg = 3'b100;
    logic [2:0]  start_cfg = 3'd5;
    logic [2:0]  mode;
    logic        ss_en, sq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pmode_supervisor #(.TICK_DIV(1), .SQ_HALF(4)) u_dut (
        .clk(clk), .rst(rst), .iout(iout), .pout(pout), .unity_ratio(unity_ratio),
        .pm_force_n(pm_force_n), .ovr_sel(ovr_sel), .ovr_panel(ovr_panel),
        .entry_cfg(entry_cfg), .start_cfg(start_cfg),
        .mode(mode), .ss_en(ss_en), .sq_out(sq_out)
    );

    function automatic int exp_dwell(input int code);
        case (code)
            0: return 20;
            1: return 40;
            2: return 100;
            default: return 200;
        endcase
    endfunction

    function automatic int exp_limit(input int refv, input bit fine);
        return fine ? (refv >> 6) : (refv >> 5);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic restart(input logic [2:0] sc, input int cur);
        rst = 1'b1; start_cfg = sc; iout = 10'(cur);
        unity_ratio = 1'b0; pm_force_n = 1'b1;
        step(2);
        rst = 1'b0;
        step(25);
        chk("R1 still soft at tick 25", int'(mode), MD_SOFT);
        step(1);
    endtask

    initial begin
        int tog, base, lim, d;
        bit fine, up;
        logic prev;
        void'($urandom(32'd2417));

        step(3);
        chk("R10 mode in reset", int'(mode), MD_OFF);
        chk("R10 ss_en in reset", int'(ss_en), 0);
        chk("R10 sq_out in reset", int'(sq_out), 0);

        rst = 1'b0;
        step(1);
        chk("R1 soft after release", int'(mode), MD_SOFT);
        chk("R1 ss_en in soft", int'(ss_en), 1);
        step(24);
        chk("R1 soft last tick", int'(mode), MD_SOFT);
        step(1);
        chk("R2 low current to hold", int'(mode), MD_HOLD);
        chk("R1 ss_en off after soft", int'(ss_en), 0);

        step(4);
        prev = sq_out; tog = 0;
        for (int i = 0; i < 16; i++) begin
            step(1);
            if (sq_out != prev) tog++;
            prev = sq_out;
        end
        chk("R9 toggles in 16 cycles", tog, 4);

        iout = 10'd80; step(10);
        chk("R4 between thresholds stays hold", int'(mode), MD_HOLD);
        iout = 10'd120; step(1);
        chk("R3 no-hold code leaves at start threshold", int'(mode), MD_MPPT);
        step(2);
        chk("R9 sq low in mppt", int'(sq_out), 0);
        iout = 10'd60; step(5);
        chk("R4 at exit threshold stays mppt", int'(mode), MD_MPPT);
        iout = 10'd59; step(1);
        chk("R4 below exit threshold to hold", int'(mode), MD_HOLD);
        iout = 10'd120; step(1);
        chk("R4 back to mppt", int'(mode), MD_MPPT);

        // dwell and power-exit sweep with random power and fraction
        for (int k = 0; k < 8; k++) begin
            base = 400 + int'($urandom_range(0, 3000));
            fine = 1'($urandom_range(0, 1));
            up   = 1'($urandom_range(0, 1));
            d    = exp_dwell(k % 4);
            entry_cfg = {~fine, 2'(k % 4)};
            pout = 16'(base);
            unity_ratio = 1'b1;
            step(d - 1);
            chk("R5 dwell not yet done", int'(mode), MD_MPPT);
            step(1);
            chk("R5 dwell done", int'(mode), MD_PANEL);
            unity_ratio = 1'b0;
            lim = exp_limit(base, fine);
            pout = 16'(up ? base + lim : base - lim);
            step(2);
            chk("R6 deviation at limit stays", int'(mode), MD_PANEL);
            pout = 16'(up ? base + lim + 1 : base - lim - 1);
            step(1);
            chk("R6 deviation past limit exits", int'(mode), MD_MPPT);
        end

        entry_cfg = 3'b100;
        unity_ratio = 1'b1; step(15);
        unity_ratio = 1'b0; step(1);
        chk("R5 broken run stays mppt", int'(mode), MD_MPPT);
        unity_ratio = 1'b1; step(19);
        chk("R5 run restarted", int'(mode), MD_MPPT);
        step(1);
        chk("R5 restarted run completes", int'(mode), MD_PANEL);
        unity_ratio = 1'b0;

        step(5999);
        chk("R7 panel before recheck", int'(mode), MD_PANEL);
        step(1);
        chk("R7 recheck entered", int'(mode), MD_RECHECK);
        step(2);
        chk("R9 sq low in recheck", int'(sq_out), 0);
        step(397);
        chk("R7 window last tick", int'(mode), MD_RECHECK);
        step(1);
        chk("R7 window over back to panel", int'(mode), MD_PANEL);

        pout = pout + 16'd1000; step(1);
        chk("R6 large change exits", int'(mode), MD_MPPT);
        pm_force_n = 1'b0; step(1);
        chk("R8 pin forces panel", int'(mode), MD_PANEL);
        pout = pout + 16'd1000; step(3);
        chk("R8 force blocks power exit", int'(mode), MD_PANEL);
        pm_force_n = 1'b1; step(1);
        chk("R8 release lets power exit", int'(mode), MD_MPPT);
        ovr_sel = 1'b1; ovr_panel = 1'b0; pm_force_n = 1'b0; step(5);
        chk("R8 override masks pin", int'(mode), MD_MPPT);
        ovr_panel = 1'b1; step(1);
        chk("R8 override bit forces panel", int'(mode), MD_PANEL);
        ovr_sel = 1'b0; ovr_panel = 1'b0; pm_force_n = 1'b1;

        rst = 1'b1; step(1);
        chk("R10 reset from panel", int'(mode), MD_OFF);
        chk("R10 ss_en low", int'(ss_en), 0);
        step(1);
        chk("R10 sq stops", int'(sq_out), 0);

        restart(3'd5, 120);
        chk("R2 current during soft to mppt", int'(mode), MD_MPPT);

        rst = 1'b1; iout = 10'd120; step(2);
        rst = 1'b0; step(5);
        iout = 10'd0; step(21);
        chk("R2 brief current remembered", int'(mode), MD_MPPT);

        restart(3'd2, 0);
        chk("R2 code 2 to hold", int'(mode), MD_HOLD);
        step(7000);
        chk("R3 hold timer waits for current", int'(mode), MD_HOLD);
        iout = 10'd120; step(6000);
        chk("R3 short hold not elapsed", int'(mode), MD_HOLD);
        step(1);
        chk("R3 short hold elapsed", int'(mode), MD_MPPT);

        restart(3'd4, 0);
        iout = 10'd120; step(12000);
        chk("R3 long hold not elapsed", int'(mode), MD_HOLD);
        step(1);
        chk("R3 long hold elapsed", int'(mode), MD_MPPT);

        restart(3'd3, 0);
        step(50);
        chk("R3 code 3 waits on current", int'(mode), MD_HOLD);
        iout = 10'd100; step(1);
        chk("R3 code 3 no timed hold", int'(mode), MD_MPPT);

        restart(3'd6, 30);
        chk("R4 light start threshold", int'(mode), MD_MPPT);
        iout = 10'd15; step(5);
        chk("R4 light exit threshold holds", int'(mode), MD_MPPT);
        iout = 10'd14; step(1);
        chk("R4 light below exit", int'(mode), MD_HOLD);

        restart(3'd7, 0);
        chk("R4 zero thresholds to mppt", int'(mode), MD_MPPT);
        step(5);
        chk("R4 zero exit never drops", int'(mode), MD_MPPT);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule